// File: doc/BRIEF.md
# Deblocking Edge Sample Filter

This block smooths one line of pixels that crosses the boundary between two 4x4 blocks of a decoded picture. For every line it receives four samples on each side of the edge, named p3..p0 on the first side and q0..q3 on the second (index 0 nearest the edge), together with a boundary-strength code and the alpha, beta and clipping thresholds that the caller has already derived from the quantization parameter. It returns the filtered line and a flag telling whether any sample changed.

The decision to filter follows the usual video-coding rules rather than a fixed kernel. A zero boundary strength or a large step across the edge leaves the line untouched, so real image edges survive. Strengths 1 to 3 apply a clipped correction to the samples next to the edge. Strength 4 or above selects the strong filter, which may rewrite up to three samples per side. A mode input selects chroma handling, where only the two samples at the edge can change. The block takes a new line every cycle and is meant to sit behind a scheduler that feeds vertical and then horizontal edges.

Top module: `dbk_edge_filter`

## Requirements
- R1: out_valid rises exactly two clock cycles after in_valid; a new line may be accepted on every cycle and lines leave in arrival order.
- R2: When the 3-bit strength code is 0, all eight output samples equal the inputs.
- R3: Filtering happens only if |p0-q0| < alpha, |p1-p0| < beta and |q1-q0| < beta; otherwise the line passes through unchanged.
- R4: p3 and q3 are never changed; at most p2..p0 and q2..q0 can differ from the input.
- R5: For strength 1 to 3, delta = clip(-tc, tc, (4*(q0-p0) + (p1-q1) + 4) >> 3) with arithmetic shift; p0 becomes p0+delta and q0 becomes q0-delta. In luma mode tc = tc0 + [|p2-p0| < beta] + [|q2-q0| < beta].
- R6: For strength 1 to 3 in luma mode, p1 changes only if |p2-p0| < beta, by clip(-tc0, tc0, (p2 + ((p0+q0+1)>>1) - 2*p1) >> 1); q1 likewise with q2, q0 and the mirrored samples.
- R7: For strength 4 or more in luma mode, when |p0-q0| < (alpha>>2)+2 and |p2-p0| < beta, p0 = (p2+2p1+2p0+2q0+q1+4)>>3, p1 = (p2+p1+p0+q0+2)>>2, p2 = (2p3+3p2+p1+p0+q0+4)>>3; otherwise only p0 = (2p1+p0+q1+2)>>2. The q side is mirrored with its own test on |q2-q0|.
- R8: In chroma mode (in_chroma=1) only p0 and q0 may change; the normal filter uses tc = tc0+1 and the strong filter always uses the 3-tap form p0 = (2p1+p0+q1+2)>>2 (mirrored for q0).
- R9: Every output sample is saturated to the range 0..2^SW-1.
- R10: out_changed is 1 exactly when at least one output sample differs from the corresponding input sample.
- R11: During and right after reset out_valid is 0.

Sample packing: in_p[SW*i +: SW] holds p_i and in_q[SW*i +: SW] holds q_i, so bits [SW-1:0] hold the samples nearest the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Line present on the inputs this cycle |
| in_p | input | 4*SW | Samples p3..p0, p0 in the low bits |
| in_q | input | 4*SW | Samples q3..q0, q0 in the low bits |
| in_bs | input | 3 | Boundary strength, 0 off, 1..3 normal, 4..7 strong |
| in_chroma | input | 1 | 1 selects chroma handling |
| in_alpha | input | SW | Edge step threshold |
| in_beta | input | SW | Side activity threshold |
| in_tc0 | input | TCW | Base clipping bound |
| out_valid | output | 1 | Filtered line present |
| out_p | output | 4*SW | Filtered p3..p0 |
| out_q | output | 4*SW | Filtered q3..q0 |
| out_changed | output | 1 | At least one sample changed |

## Verification
The assertions watch, on every cycle, the two-cycle valid latency, pass-through for zero strength and for a large edge step, the untouched outer samples, the chroma restriction, the bound on the normal correction and the consistency of the changed flag. The exact arithmetic of the normal and strong formulas, the per-side choice between strong and fallback forms, saturation at the range ends, and ordering of back-to-back lines only show up in the bench's scenarios, where a reference model computes each expected line from the requirements.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
   typedef enum logic [1:0] {
      DBK_OFF    = 2'd0,
      DBK_NORMAL = 2'd1,
      DBK_STRONG = 2'd2
   } dbk_mode_e;
endpackage

// File: rtl/dbk_gate.sv
// Stage 1: threshold decisions, clipped edge correction, registered.
module dbk_gate
   import dbk_pkg::*;
#(
   parameter int SW  = 8,
   parameter int TCW = 5,
   parameter int DW  = SW + 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [4*SW-1:0]      in_p,
   input  logic [4*SW-1:0]      in_q,
   input  logic [2:0]           in_bs,
   input  logic                 in_chroma,
   input  logic [SW-1:0]        in_alpha,
   input  logic [SW-1:0]        in_beta,
   input  logic [TCW-1:0]       in_tc0,
   output logic                 s_valid,
   output logic [4*SW-1:0]      s_p,
   output logic [4*SW-1:0]      s_q,
   output dbk_mode_e            s_mode,
   output logic                 s_chroma,
   output logic                 s_p_ok,
   output logic                 s_q_ok,
   output logic                 s_strong_ok,
   output logic signed [DW-1:0] s_delta,
   output logic [TCW-1:0]       s_tc0
);
   localparam logic signed [DW-1:0] C4 = DW'(4);

   function automatic logic [SW-1:0] absd(input logic [SW-1:0] x, input logic [SW-1:0] y);
      return (x > y) ? (x - y) : (y - x);
   endfunction

   function automatic logic signed [DW-1:0] ext(input logic [SW-1:0] v);
      return $signed({{(DW-SW){1'b0}}, v});
   endfunction

   logic [SW-1:0]        p0, p1, p2, q0, q1, q2;
   logic [SW-1:0]        step;
   logic                 open, p_ok, q_ok, strong_ok;
   logic [TCW:0]         tc;
   logic signed [DW-1:0] tcs, raw, dlt;
   dbk_mode_e            mode;

   assign p0 = in_p[0 +: SW];
   assign p1 = in_p[SW +: SW];
   assign p2 = in_p[2*SW +: SW];
   assign q0 = in_q[0 +: SW];
   assign q1 = in_q[SW +: SW];
   assign q2 = in_q[2*SW +: SW];

   assign step      = absd(p0, q0);
   assign open      = (step < in_alpha) && (absd(p1, p0) < in_beta) && (absd(q1, q0) < in_beta);
   assign p_ok      = absd(p2, p0) < in_beta;
   assign q_ok      = absd(q2, q0) < in_beta;
   assign strong_ok = {1'b0, step} < ({2'b00, in_alpha[SW-1:2]} + (SW+1)'(2));

   always_comb begin
      if (in_chroma) tc = {1'b0, in_tc0} + (TCW+1)'(1);
      else           tc = {1'b0, in_tc0} + (TCW+1)'(p_ok) + (TCW+1)'(q_ok);
      tcs = $signed({{(DW-TCW-1){1'b0}}, tc});
      raw = ((((ext(q0) - ext(p0)) <<< 2) + (ext(p1) - ext(q1))) + C4) >>> 3;
      if (raw > tcs)       dlt = tcs;
      else if (raw < -tcs) dlt = -tcs;
      else                 dlt = raw;
      if (in_bs == 3'd0 || !open) mode = DBK_OFF;
      else if (in_bs[2])          mode = DBK_STRONG;
      else                        mode = DBK_NORMAL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_valid     <= 1'b0;
         s_p         <= '0;
         s_q         <= '0;
         s_mode      <= DBK_OFF;
         s_chroma    <= 1'b0;
         s_p_ok      <= 1'b0;
         s_q_ok      <= 1'b0;
         s_strong_ok <= 1'b0;
         s_delta     <= '0;
         s_tc0       <= '0;
      end else begin
         s_valid     <= in_valid;
         s_p         <= in_p;
         s_q         <= in_q;
         s_mode      <= mode;
         s_chroma    <= in_chroma;
         s_p_ok      <= p_ok;
         s_q_ok      <= q_ok;
         s_strong_ok <= strong_ok;
         s_delta     <= dlt;
         s_tc0       <= in_tc0;
      end
   end

   AST_DELTA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (s_delta <= $signed(DW'(s_tc0) + DW'(2))) && (s_delta >= -$signed(DW'(s_tc0) + DW'(2)))); // R5
endmodule

// File: rtl/dbk_side.sv
// One side of the edge: applies normal or strong forms to a0..a2.
module dbk_side
   import dbk_pkg::*;
#(
   parameter int SW  = 8,
   parameter int TCW = 5,
   parameter int DW  = SW + 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [4*SW-1:0]      a_in,
   input  logic [SW-1:0]        b0,
   input  logic [SW-1:0]        b1,
   input  dbk_mode_e            mode,
   input  logic                 chroma,
   input  logic                 side_ok,
   input  logic                 strong_ok,
   input  logic signed [DW-1:0] delta,
   input  logic [TCW-1:0]       tc0,
   output logic [4*SW-1:0]      a_out
);
   localparam int MAXI = (1 << SW) - 1;
   localparam logic signed [DW-1:0] VMAX = DW'(MAXI);
   localparam logic signed [DW-1:0] C1 = DW'(1);
   localparam logic signed [DW-1:0] C2 = DW'(2);
   localparam logic signed [DW-1:0] C4 = DW'(4);

   function automatic logic signed [DW-1:0] ext(input logic [SW-1:0] v);
      return $signed({{(DW-SW){1'b0}}, v});
   endfunction

   function automatic logic [SW-1:0] sat(input logic signed [DW-1:0] v);
      if (v < 0)         return '0;
      else if (v > VMAX) return SW'(MAXI);
      else               return v[SW-1:0];
   endfunction

   logic signed [DW-1:0] x0, x1, x2, x3, y0, y1, tcs, d1;

   assign x0  = ext(a_in[0 +: SW]);
   assign x1  = ext(a_in[SW +: SW]);
   assign x2  = ext(a_in[2*SW +: SW]);
   assign x3  = ext(a_in[3*SW +: SW]);
   assign y0  = ext(b0);
   assign y1  = ext(b1);
   assign tcs = $signed({{(DW-TCW){1'b0}}, tc0});

   always_comb begin
      d1 = (x2 + ((x0 + y0 + C1) >>> 1) - (x1 <<< 1)) >>> 1;
      if (d1 > tcs)       d1 = tcs;
      else if (d1 < -tcs) d1 = -tcs;
      a_out = a_in;
      case (mode)
         DBK_NORMAL: begin
            a_out[0 +: SW] = sat(x0 + delta);
            if (!chroma && side_ok) a_out[SW +: SW] = sat(x1 + d1);
         end
         DBK_STRONG: begin
            if (!chroma && side_ok && strong_ok) begin
               a_out[0 +: SW]    = sat((x2 + (x1 <<< 1) + (x0 <<< 1) + (y0 <<< 1) + y1 + C4) >>> 3);
               a_out[SW +: SW]   = sat((x2 + x1 + x0 + y0 + C2) >>> 2);
               a_out[2*SW +: SW] = sat(((x3 <<< 1) + x2 + (x2 <<< 1) + x1 + x0 + y0 + C4) >>> 3);
            end else begin
               a_out[0 +: SW]    = sat(((x1 <<< 1) + x0 + y1 + C2) >>> 2);
            end
         end
         default: ;
      endcase
   end

   AST_P1_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == DBK_NORMAL && !side_ok) |-> (a_out[SW +: SW] == a_in[SW +: SW])); // R6
   AST_CHROMA_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      chroma |-> (a_out[4*SW-1:SW] == a_in[4*SW-1:SW])); // R8
endmodule

// File: rtl/dbk_edge_filter.sv
module dbk_edge_filter
   import dbk_pkg::*;
#(
   parameter int SW  = 8,
   parameter int TCW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [4*SW-1:0]   in_p,
   input  logic [4*SW-1:0]   in_q,
   input  logic [2:0]        in_bs,
   input  logic              in_chroma,
   input  logic [SW-1:0]     in_alpha,
   input  logic [SW-1:0]     in_beta,
   input  logic [TCW-1:0]    in_tc0,
   output logic              out_valid,
   output logic [4*SW-1:0]   out_p,
   output logic [4*SW-1:0]   out_q,
   output logic              out_changed
);
   localparam int DW = SW + 5;

   if (SW < 4 || TCW < 2 || TCW + 2 > SW) begin : g_bad_params
      $error("dbk_edge_filter: SW must be >= 4 and TCW in 2..SW-2");
   end

   logic                 s_valid, s_chroma, s_p_ok, s_q_ok, s_strong_ok;
   logic [4*SW-1:0]      s_p, s_q;
   dbk_mode_e            s_mode;
   logic signed [DW-1:0] s_delta;
   logic [TCW-1:0]       s_tc0;
   logic [4*SW-1:0]      side_out [2];

   dbk_gate #(.SW(SW), .TCW(TCW), .DW(DW)) gate_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_p(in_p), .in_q(in_q),
      .in_bs(in_bs), .in_chroma(in_chroma), .in_alpha(in_alpha), .in_beta(in_beta),
      .in_tc0(in_tc0), .s_valid(s_valid), .s_p(s_p), .s_q(s_q), .s_mode(s_mode),
      .s_chroma(s_chroma), .s_p_ok(s_p_ok), .s_q_ok(s_q_ok), .s_strong_ok(s_strong_ok),
      .s_delta(s_delta), .s_tc0(s_tc0)
   );

   for (genvar g = 0; g < 2; g++) begin : g_side
      dbk_side #(.SW(SW), .TCW(TCW), .DW(DW)) side_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .a_in      ((g == 0) ? s_p : s_q),
         .b0        ((g == 0) ? s_q[0 +: SW] : s_p[0 +: SW]),
         .b1        ((g == 0) ? s_q[SW +: SW] : s_p[SW +: SW]),
         .mode      (s_mode),
         .chroma    (s_chroma),
         .side_ok   ((g == 0) ? s_p_ok : s_q_ok),
         .strong_ok (s_strong_ok),
         .delta     ((g == 0) ? s_delta : -s_delta),
         .tc0       (s_tc0),
         .a_out     (side_out[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_p       <= '0;
         out_q       <= '0;
         out_changed <= 1'b0;
      end else begin
         out_valid   <= s_valid;
         out_p       <= side_out[0];
         out_q       <= side_out[1];
         out_changed <= (side_out[0] != s_p) || (side_out[1] != s_q);
      end
   end

   // Checks on the port-level behaviour, armed two cycles after reset.
   logic [1:0] arm;
   logic       big_step;
   always_ff @(posedge clk) begin
      if (!rst_n)          arm <= 2'd0;
      else if (arm != 2'd2) arm <= arm + 2'd1;
   end
   assign big_step = ((in_p[0 +: SW] > in_q[0 +: SW]) ? (in_p[0 +: SW] - in_q[0 +: SW])
                                                      : (in_q[0 +: SW] - in_p[0 +: SW])) >= in_alpha;

   AST_RESET_IDLE: assert property (@(posedge clk) (arm == 2'd0) |-> !out_valid); // R11
   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (arm == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R1
   AST_BS_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (arm == 2'd2 && $past(in_valid && in_bs == 3'd0, 2)) |->
      (out_p == $past(in_p, 2) && out_q == $past(in_q, 2))); // R2
   AST_STEP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (arm == 2'd2 && $past(in_valid && big_step, 2)) |-> !out_changed); // R3
   AST_OUTER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (arm == 2'd2 && $past(in_valid, 2)) |->
      (out_p[3*SW +: SW] == $past(in_p[3*SW +: SW], 2) &&
       out_q[3*SW +: SW] == $past(in_q[3*SW +: SW], 2))); // R4
   AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (arm == 2'd2 && $past(in_valid, 2)) |->
      (out_changed == ((out_p != $past(in_p, 2)) || (out_q != $past(in_q, 2))))); // R10
endmodule

// File: tb/dbk_edge_filter_tb.sv
`timescale 1ns/1ps
module dbk_edge_filter_tb_top;
   localparam int SW  = 8;
   localparam int TCW = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [4*SW-1:0] in_p = '0, in_q = '0;
   logic [2:0]      in_bs = '0;
   logic            in_chroma = 1'b0;
   logic [SW-1:0]   in_alpha = '0, in_beta = '0;
   logic [TCW-1:0]  in_tc0 = '0;
   logic            out_valid, out_changed;
   logic [4*SW-1:0] out_p, out_q;

   always #2 clk = ~clk;

   dbk_edge_filter #(.SW(SW), .TCW(TCW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_p(in_p), .in_q(in_q),
      .in_bs(in_bs), .in_chroma(in_chroma), .in_alpha(in_alpha), .in_beta(in_beta),
      .in_tc0(in_tc0), .out_valid(out_valid), .out_p(out_p), .out_q(out_q),
      .out_changed(out_changed)
   );

   typedef struct {
      logic [4*SW-1:0] p;
      logic [4*SW-1:0] q;
      logic            chg;
      int              due;
      string           tag;
   } exp_t;

   exp_t sb[$];
   int   checks = 0, errors = 0, cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int iabs(int v); return (v < 0) ? -v : v; endfunction
   function automatic int clip3(int lo, int hi, int v);
      return (v < lo) ? lo : ((v > hi) ? hi : v);
   endfunction

   // Reference model built from R2..R10.
   function automatic void model(input int p[4], input int q[4], input int bs, input int ch,
                                 input int al, input int be, input int t0,
                                 output int op[4], output int oq[4]);
      int ap, aq, tc, d, d1;
      bit open, sok;
      for (int i = 0; i < 4; i++) begin op[i] = p[i]; oq[i] = q[i]; end
      open = iabs(p[0]-q[0]) < al && iabs(p[1]-p[0]) < be && iabs(q[1]-q[0]) < be;
      if (bs == 0 || !open) return;
      ap  = (iabs(p[2]-p[0]) < be) ? 1 : 0;
      aq  = (iabs(q[2]-q[0]) < be) ? 1 : 0;
      sok = iabs(p[0]-q[0]) < ((al >> 2) + 2);
      if (bs < 4) begin
         tc = ch ? t0 + 1 : t0 + ap + aq;
         d  = clip3(-tc, tc, ((q[0]-p[0])*4 + (p[1]-q[1]) + 4) >>> 3);
         op[0] = clip3(0, 255, p[0] + d);
         oq[0] = clip3(0, 255, q[0] - d);
         if (!ch && ap == 1) begin
            d1 = clip3(-t0, t0, (p[2] + ((p[0]+q[0]+1) >> 1) - 2*p[1]) >>> 1);
            op[1] = clip3(0, 255, p[1] + d1);
         end
         if (!ch && aq == 1) begin
            d1 = clip3(-t0, t0, (q[2] + ((p[0]+q[0]+1) >> 1) - 2*q[1]) >>> 1);
            oq[1] = clip3(0, 255, q[1] + d1);
         end
      end else begin
         if (!ch && ap == 1 && sok) begin
            op[0] = (p[2] + 2*p[1] + 2*p[0] + 2*q[0] + q[1] + 4) >> 3;
            op[1] = (p[2] + p[1] + p[0] + q[0] + 2) >> 2;
            op[2] = (2*p[3] + 3*p[2] + p[1] + p[0] + q[0] + 4) >> 3;
         end else op[0] = (2*p[1] + p[0] + q[1] + 2) >> 2;
         if (!ch && aq == 1 && sok) begin
            oq[0] = (q[2] + 2*q[1] + 2*q[0] + 2*p[0] + p[1] + 4) >> 3;
            oq[1] = (q[2] + q[1] + q[0] + p[0] + 2) >> 2;
            oq[2] = (2*q[3] + 3*q[2] + q[1] + q[0] + p[0] + 4) >> 3;
         end else oq[0] = (2*q[1] + q[0] + p[1] + 2) >> 2;
      end
   endfunction

   // Driver: applies one line at a negative edge and queues its expectation.
   task automatic drive(input int p3, p2, p1, p0, q0, q1, q2, q3,
                        input int bs, ch, al, be, t0, input string tag);
      int p[4], q[4], op[4], oq[4];
      exp_t e;
      p = '{p0, p1, p2, p3};
      q = '{q0, q1, q2, q3};
      model(p, q, bs, ch, al, be, t0, op, oq);
      @(negedge clk);
      in_valid  = 1'b1;
      in_p      = {SW'(p3), SW'(p2), SW'(p1), SW'(p0)};
      in_q      = {SW'(q3), SW'(q2), SW'(q1), SW'(q0)};
      in_bs     = 3'(bs);
      in_chroma = ch[0];
      in_alpha  = SW'(al);
      in_beta   = SW'(be);
      in_tc0    = TCW'(t0);
      e.p   = {SW'(op[3]), SW'(op[2]), SW'(op[1]), SW'(op[0])};
      e.q   = {SW'(oq[3]), SW'(oq[2]), SW'(oq[1]), SW'(oq[0])};
      e.chg = (e.p != in_p) || (e.q != in_q);
      e.due = cyc + 2;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Monitor: pops the oldest expectation whenever a result appears.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         exp_t e;
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R1: unexpected out_valid, actual 1 expected 0");
         end else begin
            e = sb.pop_front();
            if (e.due != cyc || out_p !== e.p || out_q !== e.q || out_changed !== e.chg) begin
               errors++;
               $display("FAIL %s: actual p=%h q=%h chg=%0d cyc=%0d expected p=%h q=%h chg=%0d cyc=%0d",
                        e.tag, out_p, out_q, out_changed, cyc, e.p, e.q, e.chg, e.due);
            end
         end
      end
   end

   initial begin
      int w;
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R11: out_valid in reset, actual %0d expected 0", out_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R11: out_valid after reset, actual %0d expected 0", out_valid);
      end

      drive(60, 62, 64, 66, 74, 76, 78, 80, 0, 0, 40, 10, 4, "R2 zero strength");
      drive(60, 62, 64, 66, 120, 122, 124, 126, 2, 0, 40, 10, 4, "R3 step over alpha");
      drive(60, 62, 40, 66, 70, 72, 74, 76, 2, 0, 40, 10, 4, "R3 p-side beta fail");
      drive(60, 62, 64, 66, 70, 90, 74, 76, 2, 0, 40, 10, 4, "R3 q-side beta fail");
      drive(60, 62, 64, 66, 74, 76, 95, 80, 1, 0, 40, 10, 4, "R5/R6 normal luma, q2 far");
      drive(80, 80, 80, 80, 110, 110, 110, 110, 3, 0, 40, 40, 1, "R5 delta clipped to tc");
      drive(90, 100, 70, 70, 72, 72, 72, 72, 2, 0, 40, 40, 2, "R6 p1 change clipped to tc0");
      drive(50, 52, 54, 56, 62, 64, 66, 68, 4, 0, 40, 10, 4, "R7 strong both sides");
      drive(50, 52, 54, 56, 70, 72, 74, 76, 4, 0, 40, 10, 4, "R7 strong fallback step");
      drive(50, 40, 54, 56, 60, 62, 64, 68, 4, 0, 40, 10, 4, "R7 strong fallback p side");
      drive(60, 62, 64, 66, 74, 76, 78, 80, 2, 1, 40, 10, 4, "R8 chroma normal");
      drive(50, 52, 54, 56, 62, 64, 66, 68, 5, 1, 40, 10, 4, "R8 chroma strong");
      drive(255, 255, 255, 250, 255, 10, 10, 10, 2, 0, 200, 255, 31, "R9 saturation high");
      drive(0, 0, 0, 5, 0, 245, 245, 245, 2, 0, 200, 255, 31, "R9 saturation low");
      drive(70, 70, 70, 70, 70, 70, 70, 70, 3, 0, 40, 10, 4, "R10 flat line unchanged");
      drive(10, 20, 30, 40, 40, 50, 60, 70, 1, 0, 40, 40, 0, "R4 R10 ramp");
      idle(3);

      for (int i = 0; i < 400; i++) begin
         int b = 16 + int'($urandom_range(0, 220));
         int v[8];
         for (int k = 0; k < 8; k++) v[k] = b + int'($urandom_range(0, 18)) - 9;
         drive(v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7],
               int'($urandom_range(0, 7)), int'($urandom_range(0, 1)),
               int'($urandom_range(0, 60)), int'($urandom_range(0, 18)),
               int'($urandom_range(0, 31)), "R1 R5 R7 R8 random line");
         if ($urandom_range(0, 7) == 0) idle(1);
      end
      idle(1);

      w = 0;
      while (sb.size() != 0 && w < 1000) begin
         @(negedge clk);
         w++;
      end
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R1: lines never delivered, actual %0d pending expected 0", sb.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 20000);
      errors++;
      checks++;
      $display("FAIL R1: watchdog expired, actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule